// File: doc/BRIEF.md
# Directory Coherence State Controller

This block holds the coherence directory for a set of memory blocks shared by a few processors. Each directory entry records one of three block states, Uncached, Shared or Exclusive, along with a presence vector that has one bit per processor. Every incoming request names a processor, an operation (read or write) and a block. The controller computes the entry's next state and presence vector, writes them back, and reports the commands the caches need: an invalidate vector addressed to the processors that must drop their copy, and a write-back request addressed to the processor that owns the block.

Requests enter on a valid/ready stream. After reset, `req_ready` stays high, so one request is accepted on every cycle in which `req_valid` is also high. There is no back-pressure beyond that. The response is a single-cycle pulse in the cycle after acceptance, and nothing can stall it. A request to a block that was updated in the cycle before sees the updated entry. `req_cpu` must be below the processor count. Interconnect, cache arrays and data movement are not part of this block.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: During reset `req_ready` and `rsp_valid` are low. Once reset is released, every entry is Uncached with an all-zero presence vector. In every entry, Uncached and an empty vector always occur together.
- R2: Once reset is released, `req_ready` is high. Each cycle with `req_valid` and `req_ready` both high produces exactly one `rsp_valid` pulse in the next cycle. `rsp_valid` is low after any cycle with no accepted request.
- R3: A read of an Uncached block makes it Shared, with only the requester's bit set. It produces no invalidate and no write-back.
- R4: A read of a Shared block keeps it Shared and adds the requester's bit to the existing bits. It produces no invalidate and no write-back.
- R5: A read of an Exclusive block by a processor other than the owner asserts `rsp_wb` with `rsp_wb_cpu` set to the owner. The block becomes Shared, with the owner's bit and the requester's bit set. A read by the owner leaves the entry unchanged and issues no command.
- R6: A write to an Uncached or Shared block makes it Exclusive with only the writer's bit set. `rsp_inv` then holds every other previously set bit. An Exclusive entry always has exactly one bit set, and `rsp_inv` never overlaps the reported vector.
- R7: A write to a block held Exclusive by another processor asserts `rsp_wb` toward the old owner and invalidates the old owner. Only the writer's bit remains set.
- R8: A write by the current Exclusive owner, or by the only Shared holder, gives Exclusive with the writer's bit only. It produces no invalidate and no write-back.
- R9: A request changes only the entry selected by `req_blk`.
- R10: States are encoded as Uncached=0, Shared=1 and Exclusive=2, with bit i of a vector standing for processor i. `rsp_state` and `rsp_sharers` report the entry after the update. A response never reports Uncached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_cpu | input | IDW | Requesting processor number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_blk | input | AW | Directory entry index |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_inv | output | NCPU | Processors to invalidate |
| rsp_wb | output | 1 | Owner must write the block back |
| rsp_wb_cpu | output | IDW | Processor targeted by the write-back |
| rsp_state | output | 2 | Entry state after the update |
| rsp_sharers | output | NCPU | Presence vector after the update |

## Verification
The bench sends back-to-back requests to the same block so that each one depends on the entry written in the cycle before. A design that reads a stale entry would report the wrong sharers or miss a write-back. Directed steps cover an owner reading or writing its own Exclusive block and a sole sharer upgrading to Exclusive. A design that confused these cases would issue needless write-backs or would invalidate the requester itself. A steal of an Exclusive block by another writer checks that the old owner is both written back and invalidated. Random traffic concentrated on a few blocks, with some spread over all of them, catches updates leaking into neighbouring entries.

// File: rtl/dircoh_pkg.sv
package dircoh_pkg;
  typedef enum logic [1:0] {
    BLK_UNCACHED = 2'd0,
    BLK_SHARED   = 2'd1,
    BLK_EXCL     = 2'd2
  } blk_state_e;
endpackage

// File: rtl/dircoh_store.sv
module dircoh_store
  import dircoh_pkg::*;
#(
  parameter int NCPU = 3,
  parameter int NBLK = 16,
  localparam int AW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_idx,
  output blk_state_e      rd_state,
  output logic [NCPU-1:0] rd_vec,
  input  logic            we,
  input  logic [AW-1:0]   wr_idx,
  input  blk_state_e      wr_state,
  input  logic [NCPU-1:0] wr_vec
);
  blk_state_e      st_q  [NBLK];
  logic [NCPU-1:0] vec_q [NBLK];

  for (genvar g = 0; g < NBLK; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]  <= BLK_UNCACHED;
        vec_q[g] <= '0;
      end else if (we && (wr_idx == AW'(g))) begin
        st_q[g]  <= wr_state;
        vec_q[g] <= wr_vec;
      end
    end

    // Uncached and an empty presence vector always go together
    assert_uncached_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == BLK_UNCACHED) == (vec_q[g] == '0));
  end

  assign rd_state = st_q[rd_idx];
  assign rd_vec   = vec_q[rd_idx];
endmodule

// File: rtl/dircoh_next.sv
module dircoh_next
  import dircoh_pkg::*;
#(
  parameter int NCPU = 3,
  localparam int IDW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  blk_state_e      cur_state,
  input  logic [NCPU-1:0] cur_vec,
  input  logic [IDW-1:0]  req_cpu,
  input  logic            req_write,
  output blk_state_e      nxt_state,
  output logic [NCPU-1:0] nxt_vec,
  output logic [NCPU-1:0] inv_vec,
  output logic            wb,
  output logic [IDW-1:0]  wb_cpu
);
  logic [NCPU-1:0] req_bit;
  logic [IDW-1:0]  owner;
  logic            req_holds;

  always_comb begin
    req_bit = '0;
    owner   = '0;
    for (int i = 0; i < NCPU; i++) begin
      if (req_cpu == IDW'(i)) req_bit[i] = 1'b1;
      if (cur_vec[i])         owner      = IDW'(i);
    end
    req_holds = (cur_vec & req_bit) != '0;
  end

  always_comb begin
    nxt_state = cur_state;
    nxt_vec   = cur_vec;
    inv_vec   = '0;
    wb        = 1'b0;
    wb_cpu    = owner;
    if (!req_write) begin
      unique case (cur_state)
        BLK_SHARED: nxt_vec = cur_vec | req_bit;
        BLK_EXCL: begin
          if (!req_holds) begin
            wb        = 1'b1;
            nxt_state = BLK_SHARED;
            nxt_vec   = cur_vec | req_bit;
          end
        end
        default: begin
          nxt_state = BLK_SHARED;
          nxt_vec   = req_bit;
        end
      endcase
    end else begin
      nxt_state = BLK_EXCL;
      nxt_vec   = req_bit;
      inv_vec   = cur_vec & ~req_bit;
      wb        = (cur_state == BLK_EXCL) && !req_holds;
    end
  end
endmodule

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl
  import dircoh_pkg::*;
#(
  parameter int NCPU = 3,
  parameter int NBLK = 16,
  localparam int IDW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int AW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [IDW-1:0]  req_cpu,
  input  logic            req_write,
  input  logic [AW-1:0]   req_blk,
  output logic            rsp_valid,
  output logic [NCPU-1:0] rsp_inv,
  output logic            rsp_wb,
  output logic [IDW-1:0]  rsp_wb_cpu,
  output logic [1:0]      rsp_state,
  output logic [NCPU-1:0] rsp_sharers
);
  logic            ready_q;
  logic            accept;
  blk_state_e      cur_state, nxt_state;
  logic [NCPU-1:0] cur_vec, nxt_vec, inv_vec;
  logic            wb;
  logic [IDW-1:0]  wb_cpu;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign req_ready = ready_q;
  assign accept    = req_valid && ready_q;

  dircoh_store #(.NCPU(NCPU), .NBLK(NBLK)) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_blk),
    .rd_state (cur_state),
    .rd_vec   (cur_vec),
    .we       (accept),
    .wr_idx   (req_blk),
    .wr_state (nxt_state),
    .wr_vec   (nxt_vec)
  );

  dircoh_next #(.NCPU(NCPU)) i_next (
    .cur_state (cur_state),
    .cur_vec   (cur_vec),
    .req_cpu   (req_cpu),
    .req_write (req_write),
    .nxt_state (nxt_state),
    .nxt_vec   (nxt_vec),
    .inv_vec   (inv_vec),
    .wb        (wb),
    .wb_cpu    (wb_cpu)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_inv     <= '0;
      rsp_wb      <= 1'b0;
      rsp_wb_cpu  <= '0;
      rsp_state   <= BLK_UNCACHED;
      rsp_sharers <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_inv     <= inv_vec;
        rsp_wb      <= wb;
        rsp_wb_cpu  <= wb_cpu;
        rsp_state   <= nxt_state;
        rsp_sharers <= nxt_vec;
      end else begin
        rsp_inv <= '0;
        rsp_wb  <= 1'b0;
      end
    end
  end

  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  assert_no_spurious_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);
  assert_excl_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_state == BLK_EXCL) |-> ($countones(rsp_sharers) == 1));
  assert_inv_disjoint_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_inv & rsp_sharers) == '0));
  assert_wb_target_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wb) |-> (int'(rsp_wb_cpu) < NCPU));
  assert_never_uncached_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_state != BLK_UNCACHED && rsp_sharers != '0));
endmodule

// File: tb/test_dir_coherence_ctrl.sv
`timescale 1ns/1ps
module test_dir_coherence_ctrl;
  localparam int NCPU = 3;
  localparam int NBLK = 16;
  localparam int IDW  = 2;
  localparam int AW   = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic [IDW-1:0]  req_cpu;
  logic            req_write;
  logic [AW-1:0]   req_blk;
  logic            rsp_valid;
  logic [NCPU-1:0] rsp_inv;
  logic            rsp_wb;
  logic [IDW-1:0]  rsp_wb_cpu;
  logic [1:0]      rsp_state;
  logic [NCPU-1:0] rsp_sharers;

  dir_coherence_ctrl #(.NCPU(NCPU), .NBLK(NBLK)) i_dir_coherence_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cpu(req_cpu), .req_write(req_write), .req_blk(req_blk),
    .rsp_valid(rsp_valid), .rsp_inv(rsp_inv), .rsp_wb(rsp_wb),
    .rsp_wb_cpu(rsp_wb_cpu), .rsp_state(rsp_state), .rsp_sharers(rsp_sharers)
  );

  int checks = 0;
  int errors = 0;
  int m_st  [NBLK];
  int m_vec [NBLK];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Expected entry update computed from the requirement text
  task automatic do_req(int cpu, int wr, int blk, string note);
    int st = m_st[blk];
    int v  = m_vec[blk];
    int rb = 1 << cpu;
    int owner = 0;
    int e_st = 0;
    int e_v = 0;
    int e_inv = 0;
    int e_wb = 0;
    string tg = "";
    for (int i = 0; i < NCPU; i++) if (v[i]) owner = i;
    if (wr == 0) begin
      if (st == 0)             begin e_st = 1; e_v = rb;     tg = "R3"; end
      else if (st == 1)        begin e_st = 1; e_v = v | rb; tg = "R4"; end
      else if ((v & rb) != 0)  begin e_st = 2; e_v = v;      tg = "R5"; end
      else begin e_st = 1; e_v = v | rb; e_wb = 1; tg = "R5"; end
    end else begin
      e_st = 2; e_v = rb; e_inv = v & ~rb;
      if (st == 2 && (v & rb) == 0) begin e_wb = 1; tg = "R7"; end
      else if (v == rb || v == 0)   tg = (v == rb) ? "R8" : "R6";
      else                          tg = "R6";
    end
    req_cpu   = IDW'(cpu);
    req_write = wr[0];
    req_blk   = AW'(blk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({"R2 ", note}, "rsp_valid", int'(rsp_valid), 1);
    chk({tg, "/R10 ", note}, "state", int'(rsp_state), e_st);
    chk({tg, "/R9 ", note}, "sharers", int'(rsp_sharers), e_v);
    chk({tg, " ", note}, "inv", int'(rsp_inv), e_inv);
    chk({tg, " ", note}, "wb", int'(rsp_wb), e_wb);
    if (e_wb != 0) chk({tg, " ", note}, "wb_cpu", int'(rsp_wb_cpu), owner);
    m_st[blk]  = e_st;
    m_vec[blk] = e_v;
  endtask

  task automatic idle();
    @(negedge clk);
    chk("R2", "idle rsp_valid", int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; req_valid = 1'b0; req_cpu = '0; req_write = 1'b0; req_blk = '0;
    for (int b = 0; b < NBLK; b++) begin m_st[b] = 0; m_vec[b] = 0; end
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", int'(req_ready), 0);
    chk("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "ready after reset", int'(req_ready), 1);
    chk("R2", "no response after reset", int'(rsp_valid), 0);

    // R1: every entry starts Uncached, a first read sees that
    for (int b = 0; b < NBLK; b++) do_req(b % NCPU, 0, b, "R1");
    idle();

    // Directed sequence on one block, back to back
    do_req(1, 1, 7, "sole sharer upgrade");
    do_req(1, 1, 7, "owner rewrite");
    do_req(1, 0, 7, "owner read");
    do_req(0, 0, 7, "remote read of exclusive");
    do_req(2, 0, 7, "add sharer");
    do_req(2, 1, 7, "write with sharers");
    do_req(0, 1, 7, "exclusive steal");
    idle();
    do_req(2, 1, 3, "write over shared");
    do_req(1, 0, 3, "read after write");

    // R9: random traffic, mostly on a few blocks, checked against the model
    for (int n = 0; n < 3000; n++) begin
      int blk = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, NBLK - 1))
                                            : int'($urandom_range(0, 2));
      do_req(int'($urandom_range(0, NCPU - 1)), int'($urandom_range(0, 1)), blk, "R9 random");
      if ($urandom_range(0, 9) == 0) idle();
    end
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule